// File: doc/BRIEF.md
# Serial Chain Bypass Test Controller

This block runs a built-in test over a row of identical function units that are wired into one serial chain. Each unit holds one flip-flop and a small multiplexer network. In bypass it copies its chain input into its flip-flop. In test mode it computes the next flip-flop value from a two-input truth table, chosen by the shared configuration select and indexed by its chain input and its own flip-flop. The controller drives the chain input, one test-enable line per unit and the configuration select. It watches the single chain output.

A run starts from idle on a `start` pulse. It first checks chain integrity with every unit in bypass by shifting an alternating bit stream through the whole chain. It then walks the units from index 0 upwards. Each unit gets eleven configurations in turn while every other unit stays in bypass. Only one unit is ever out of bypass, so the first mismatch at the chain output identifies the faulty unit directly. The run ends with a one-cycle `done` pulse. On a failure the run stops early and latches `fail` and the index of the failing unit, which reads all-ones for a broken chain.

Top module: `sct_chain_test_ctrl`

## Requirements
- R1: A synchronous active-low reset returns the controller to idle within one clock edge. In idle `test_en` is all zero, `chain_in` is 0, and `done`, `fail` and `fail_idx` are 0.
- R2: A `start` high in idle begins a run at the next edge. A `start` high during a run is ignored and does not change its timing.
- R3: The integrity phase lasts 3N cycles, counted k = 0..3N-1, with all units in bypass. `chain_in` equals bit 0 of k for k < 2N and is 0 after that. During k = N..3N-1 the chain output must equal bit 0 of (k-N).
- R4: An integrity mismatch stops the run, sets `fail` and sets `fail_idx` to all ones (width clog2(N+1)). `done` pulses on the same edge.
- R5: After integrity, units u = 0..N-1 are tested in order. Each unit gets configurations c = 0..10 in order, each in a slot of N+L cycles counted k = 0..N+L-1 (L = PAT_LEN). `cfg_sel` equals c, and `test_en` is one-hot on bit u exactly for k = u..u+L-1, and zero otherwise.
- R6: In configuration c the unit truth table is T = (7c+5) mod 16, with the next flip-flop value given by T[{d,q}] (d = unit input, q = its flip-flop). `chain_in` is bit k of P = (45c+150) mod 65536 for k < L, and 0 after that.
- R7: The expected chain output at slot cycle k = N+j (j = 0..L-1) is s(j+1), where s(0)=0 and s(i+1) = T[{P[i], s(i)}].
- R8: A mismatch in a unit slot stops the run, sets `fail` and latches the unit index u in `fail_idx`. Any configuration whose faulty response equals the fault-free response lets the run continue.
- R9: A run with no mismatch raises `done` for exactly one cycle, 3N + 11·N·(N+L) cycles after the start edge, with `fail` left at 0.
- R10: `fail` and `fail_idx` hold their values in idle until the next accepted `start` clears them.
- R11: At most one `test_en` bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| chain_out | input | 1 | Serial output of the last unit in the chain |
| test_en | output | N_UNITS | Per-unit test mode select, 0 = bypass |
| cfg_sel | output | 4 | Configuration index 0..10 for the unit under test |
| chain_in | output | 1 | Serial stimulus into the first unit |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Latched failure flag |
| fail_idx | output | clog2(N_UNITS+1) | Failing unit index, all ones for a chain break |

## Verification
The bench models the chain and runs it fault-free, once with a full cycle-by-cycle comparison of stimulus and selects, and once with a stray `start` in the middle. It then sweeps one flipped truth-table bit over every unit, every configuration and each of the four table positions. For each case it works out whether the flip changes that configuration's response, so it can tell a caught fault with the right index from a masked one that must run to a clean `done`. Stuck-at-0 and stuck-at-1 outputs on each unit separate integrity failures from unit failures, and a reset mid-run checks the return to all-bypass idle.

// File: rtl/sct_pkg.sv
// Shared definitions for the serial chain test controller.
// Assumes the pattern length never exceeds 16 bits.
package sct_pkg;

    localparam int NUM_CFG = 11;
    localparam int CFG_W   = 4;
    localparam int PAT_MAX = 16;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LINK = 2'd1,
        PH_UNIT = 2'd2
    } phase_t;

    // Two-input truth table used by a unit under test in configuration c
    function automatic logic [3:0] cfg_truth(input logic [CFG_W-1:0] c);
        int v;
        v = int'(c) * 7 + 5;
        return v[3:0];
    endfunction

    // Serial stimulus word for configuration c, bit k sent in slot cycle k
    function automatic logic [PAT_MAX-1:0] cfg_pattern(input logic [CFG_W-1:0] c);
        int v;
        v = int'(c) * 45 + 150;
        return v[PAT_MAX-1:0];
    endfunction

    // Fault-free flip-flop sequence of a unit fed with the pattern from state 0
    function automatic logic [PAT_MAX-1:0] cfg_response(input logic [CFG_W-1:0] c);
        logic [3:0]         tt;
        logic [PAT_MAX-1:0] pat;
        logic [PAT_MAX-1:0] rsp;
        logic               st;
        tt  = cfg_truth(c);
        pat = cfg_pattern(c);
        st  = 1'b0;
        rsp = '0;
        for (int j = 0; j < PAT_MAX; j++) begin
            st     = tt[{pat[j], st}];
            rsp[j] = st;
        end
        return rsp;
    endfunction

endpackage

// File: rtl/sct_sequencer.sv
// Phase sequencer: idle, chain integrity, then a slot per (unit, config).
// Assumes abort is only raised while a phase other than idle is running.
module sct_sequencer
    import sct_pkg::*;
#(
    parameter int N_UNITS = 4,
    parameter int PAT_LEN = 6,
    parameter int CNT_W   = 5,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    output phase_t           phase,
    output logic [IDX_W-1:0] unit_idx,
    output logic [CFG_W-1:0] cfg_idx,
    output logic [CNT_W-1:0] cnt,
    output logic             start_ok,
    output logic             run_end
);

    localparam logic [CNT_W-1:0] LINK_LAST = CNT_W'(3 * N_UNITS - 1);
    localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(N_UNITS + PAT_LEN - 1);
    localparam logic [IDX_W-1:0] UNIT_LAST = IDX_W'(N_UNITS - 1);
    localparam logic [CFG_W-1:0] CFG_LAST  = CFG_W'(NUM_CFG - 1);

    logic slot_last;

    // Decode of the final cycle of a slot and of the whole run
    always_comb begin
        start_ok  = start && (phase == PH_IDLE);
        slot_last = (phase == PH_UNIT) && (cnt == SLOT_LAST);
        run_end   = slot_last && (cfg_idx == CFG_LAST) && (unit_idx == UNIT_LAST);
    end

    // Phase, unit, configuration and cycle counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            unit_idx <= '0;
            cfg_idx  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase    <= PH_LINK;
                        cnt      <= '0;
                        unit_idx <= '0;
                        cfg_idx  <= '0;
                    end
                end
                PH_LINK: begin
                    if (abort) begin
                        phase <= PH_IDLE;
                    end else if (cnt == LINK_LAST) begin
                        phase <= PH_UNIT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_UNIT: begin
                    if (abort) begin
                        phase <= PH_IDLE;
                    end else if (slot_last) begin
                        cnt <= '0;
                        if (cfg_idx == CFG_LAST) begin
                            cfg_idx <= '0;
                            if (unit_idx == UNIT_LAST) begin
                                phase <= PH_IDLE;
                            end else begin
                                unit_idx <= unit_idx + 1'b1;
                            end
                        end else begin
                            cfg_idx <= cfg_idx + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sct_stimulus.sv
// Stimulus and expectation decoder: chain input bit, per-unit test enables,
// expected chain output and the window in which it is compared.
// Assumes PAT_LEN <= 16 and that the chain holds zeros at each slot start.
module sct_stimulus
    import sct_pkg::*;
#(
    parameter int N_UNITS = 4,
    parameter int PAT_LEN = 6,
    parameter int CNT_W   = 5,
    parameter int IDX_W   = 3
) (
    input  phase_t             phase,
    input  logic [IDX_W-1:0]   unit_idx,
    input  logic [CFG_W-1:0]   cfg_idx,
    input  logic [CNT_W-1:0]   cnt,
    output logic               chain_in,
    output logic [N_UNITS-1:0] test_en,
    output logic               exp_bit,
    output logic               chk_en
);

    localparam logic [CNT_W-1:0] N_CNT    = CNT_W'(N_UNITS);
    localparam logic [CNT_W-1:0] TWO_N    = CNT_W'(2 * N_UNITS);
    localparam logic [CNT_W-1:0] L_CNT    = CNT_W'(PAT_LEN);
    localparam logic [CNT_W-1:0] WIN_END  = CNT_W'(N_UNITS + PAT_LEN);
    localparam logic             N_ODD    = (N_UNITS % 2) != 0;

    logic [PAT_MAX-1:0] pat;
    logic [PAT_MAX-1:0] rsp;

    // Table lookup for the configuration currently applied
    always_comb begin
        pat = cfg_pattern(cfg_idx);
        rsp = cfg_response(cfg_idx);
    end

    // Serial stimulus and expected response per phase and slot cycle
    always_comb begin
        chain_in = 1'b0;
        exp_bit  = 1'b0;
        chk_en   = 1'b0;
        case (phase)
            PH_LINK: begin
                chain_in = (cnt < TWO_N) ? cnt[0] : 1'b0;
                chk_en   = (cnt >= N_CNT);
                exp_bit  = cnt[0] ^ N_ODD;
            end
            PH_UNIT: begin
                for (int j = 0; j < PAT_LEN; j++) begin
                    if (cnt == CNT_W'(j)) begin
                        chain_in = pat[j];
                    end
                    if (cnt == CNT_W'(N_UNITS + j)) begin
                        exp_bit = rsp[j];
                    end
                end
                chk_en = (cnt >= N_CNT) && (cnt < WIN_END) && (L_CNT != '0);
            end
            default: ;
        endcase
    end

    // One test-enable window per unit, open while its pattern passes
    for (genvar g = 0; g < N_UNITS; g++) begin : g_sel
        localparam logic [CNT_W-1:0] WIN_LO = CNT_W'(g);
        localparam logic [CNT_W-1:0] WIN_HI = CNT_W'(g + PAT_LEN);
        assign test_en[g] = (phase == PH_UNIT) && (unit_idx == IDX_W'(g))
                            && (cnt >= WIN_LO) && (cnt < WIN_HI);
    end

endmodule

// File: rtl/sct_verdict.sv
// Compares the chain output against the expectation and keeps the result.
// Assumes chk_en is low whenever the sequencer is idle.
module sct_verdict
    import sct_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_ok,
    input  logic             chk_en,
    input  logic             exp_bit,
    input  logic             chain_out,
    input  phase_t           phase,
    input  logic [IDX_W-1:0] unit_idx,
    input  logic             run_end,
    output logic             mismatch,
    output logic             done,
    output logic             fail,
    output logic [IDX_W-1:0] fail_idx
);

    // Mismatch in the current compare window
    always_comb begin
        mismatch = chk_en && (chain_out != exp_bit);
    end

    // End pulse, failure flag and failing unit latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            fail     <= 1'b0;
            fail_idx <= '0;
        end else begin
            done <= run_end || mismatch;
            if (start_ok) begin
                fail     <= 1'b0;
                fail_idx <= '0;
            end else if (mismatch) begin
                fail     <= 1'b1;
                fail_idx <= (phase == PH_LINK) ? '1 : unit_idx;
            end
        end
    end

endmodule

// File: rtl/sct_chain_test_ctrl.sv
// Top of the serial chain bypass test controller. Drives a chain of
// N_UNITS function units, one of which at most leaves bypass at a time.
// Assumes the chain adds one register per unit between chain_in and chain_out
// and PAT_LEN is in 1..16.
module sct_chain_test_ctrl
    import sct_pkg::*;
#(
    parameter int N_UNITS = 4,
    parameter int PAT_LEN = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         chain_out,
    output logic [N_UNITS-1:0]           test_en,
    output logic [CFG_W-1:0]             cfg_sel,
    output logic                         chain_in,
    output logic                         done,
    output logic                         fail,
    output logic [$clog2(N_UNITS+1)-1:0] fail_idx
);

    localparam int IDX_W   = $clog2(N_UNITS + 1);
    localparam int CNT_MAX = (3 * N_UNITS > N_UNITS + PAT_LEN) ? 3 * N_UNITS : N_UNITS + PAT_LEN;
    localparam int CNT_RAW = $clog2(CNT_MAX + 1);
    localparam int CNT_W   = (CNT_RAW < 5) ? 5 : CNT_RAW;

    phase_t           phase;
    logic [IDX_W-1:0] unit_idx;
    logic [CFG_W-1:0] cfg_idx;
    logic [CNT_W-1:0] cnt;
    logic             start_ok;
    logic             run_end;
    logic             exp_bit;
    logic             chk_en;
    logic             mismatch;

    sct_sequencer #(
        .N_UNITS (N_UNITS),
        .PAT_LEN (PAT_LEN),
        .CNT_W   (CNT_W),
        .IDX_W   (IDX_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .abort    (mismatch),
        .phase    (phase),
        .unit_idx (unit_idx),
        .cfg_idx  (cfg_idx),
        .cnt      (cnt),
        .start_ok (start_ok),
        .run_end  (run_end)
    );

    sct_stimulus #(
        .N_UNITS (N_UNITS),
        .PAT_LEN (PAT_LEN),
        .CNT_W   (CNT_W),
        .IDX_W   (IDX_W)
    ) u_stim (
        .phase    (phase),
        .unit_idx (unit_idx),
        .cfg_idx  (cfg_idx),
        .cnt      (cnt),
        .chain_in (chain_in),
        .test_en  (test_en),
        .exp_bit  (exp_bit),
        .chk_en   (chk_en)
    );

    sct_verdict #(
        .IDX_W (IDX_W)
    ) u_verd (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_ok  (start_ok),
        .chk_en    (chk_en),
        .exp_bit   (exp_bit),
        .chain_out (chain_out),
        .phase     (phase),
        .unit_idx  (unit_idx),
        .run_end   (run_end),
        .mismatch  (mismatch),
        .done      (done),
        .fail      (fail),
        .fail_idx  (fail_idx)
    );

    // Configuration select follows the slot counter directly
    assign cfg_sel = cfg_idx;

endmodule

// File: rtl/sct_chain_test_chk.sv
// Port-level property checker for the chain test controller, bound to the top.
module sct_chain_test_chk #(
    parameter int N_UNITS = 4,
    parameter int PAT_LEN = 6
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         start,
    input logic [N_UNITS-1:0]           test_en,
    input logic [3:0]                   cfg_sel,
    input logic                         chain_in,
    input logic                         done,
    input logic                         fail,
    input logic [$clog2(N_UNITS+1)-1:0] fail_idx
);

    localparam int IDX_W = $clog2(N_UNITS + 1);
    localparam logic [IDX_W-1:0] ALL1 = '1;
    localparam int UNUSED_L = PAT_LEN;

    a_r11_single_unit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(test_en));

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (test_en == '0 && !chain_in && !done && !fail && fail_idx == '0));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (test_en == '0 && !chain_in));

    a_r10_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> (fail && $stable(fail_idx)));

    a_r8_fail_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (fail_idx == ALL1 || int'(fail_idx) < N_UNITS));

    a_r4_fail_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> done);

    a_r5_cfg_range: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sel < 4'd11);

endmodule

bind sct_chain_test_ctrl sct_chain_test_chk #(
    .N_UNITS (N_UNITS),
    .PAT_LEN (PAT_LEN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .test_en  (test_en),
    .cfg_sel  (cfg_sel),
    .chain_in (chain_in),
    .done     (done),
    .fail     (fail),
    .fail_idx (fail_idx)
);

// File: tb/sct_chain_test_ctrl_test.sv
// Bench: behavioural chain of units with injectable faults, swept exhaustively.
module sct_chain_test_ctrl_test;

    localparam int N = 4;
    localparam int L = 6;
    localparam int IW = $clog2(N + 1);
    localparam int RUN_LEN = 3 * N + 11 * N * (N + L);
    localparam int ALL1 = (1 << IW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          chain_out;
    logic [N-1:0]  test_en;
    logic [3:0]    cfg_sel;
    logic          chain_in;
    logic          done;
    logic          fail;
    logic [IW-1:0] fail_idx;

    int n_tests = 0;
    int n_fail  = 0;

    // fault controls of the chain model
    int   f_unit = -1;
    int   f_cfg  = -1;
    int   f_mask = 0;
    int   s_unit = -1;
    logic s_val  = 1'b0;

    logic [N-1:0] q = '0;
    logic [N-1:0] qn;

    always #10ns clk = ~clk;

    sct_chain_test_ctrl #(.N_UNITS(N), .PAT_LEN(L)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .chain_out (chain_out),
        .test_en   (test_en),
        .cfg_sel   (cfg_sel),
        .chain_in  (chain_in),
        .done      (done),
        .fail      (fail),
        .fail_idx  (fail_idx)
    );

    function automatic int b_tt(input int c);
        return (7 * c + 5) % 16;
    endfunction

    function automatic int b_pat(input int c);
        return (45 * c + 150) % 65536;
    endfunction

    function automatic int b_resp(input int c, input int mask);
        int t = b_tt(c) ^ mask;
        int s = 0;
        int r = 0;
        for (int j = 0; j < L; j++) begin
            int d = (b_pat(c) >> j) & 1;
            s = (t >> (2 * d + s)) & 1;
            r = r | (s << j);
        end
        return r;
    endfunction

    // chain model next state
    always_comb begin
        logic din;
        int   t;
        for (int i = 0; i < N; i++) begin
            din = (i == 0) ? chain_in : q[i-1];
            t   = b_tt(int'(cfg_sel)) ^ ((i == f_unit && int'(cfg_sel) == f_cfg) ? f_mask : 0);
            if (i == s_unit)      qn[i] = s_val;
            else if (test_en[i])  qn[i] = t[{din, q[i]}];
            else                  qn[i] = din;
        end
    end

    always_ff @(posedge clk) q <= qn;
    assign chain_out = q[N-1];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected stimulus at run cycle t
    task automatic exp_stim(input int t, output int te, output int ci, output int cf);
        if (t < 3 * N) begin
            te = 0;
            ci = (t < 2 * N) ? (t & 1) : 0;
            cf = -1;
        end else begin
            int u = t - 3 * N;
            int k = u / (11 * (N + L));
            int r = u % (11 * (N + L));
            int c = r / (N + L);
            int n = r % (N + L);
            te = (n >= k && n < k + L) ? (1 << k) : 0;
            ci = (n < L) ? ((b_pat(c) >> n) & 1) : 0;
            cf = c;
        end
    endtask

    // one complete run; exp_fl: expected fail, exp_ix: expected index
    task automatic run_case(input int exp_fl, input int exp_ix, input string req,
                            input bit chk_stim, input bit stray);
        int t = 0;
        int bad_t = -1;
        int te, ci, cf;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done && t <= RUN_LEN + 2) begin
            if (chk_stim && bad_t < 0) begin
                exp_stim(t, te, ci, cf);
                if (int'(test_en) != te || int'(chain_in) != ci ||
                    (cf >= 0 && int'(cfg_sel) != cf))
                    bad_t = t;
            end
            start = stray && (t == 100);
            @(negedge clk);
            t++;
        end
        start = 1'b0;
        if (chk_stim)
            check(bad_t < 0, "R3 R5 R6 stimulus cycle", bad_t, -1);
        check(done == 1'b1, {req, " done seen"}, int'(done), 1);
        check(int'(fail) == exp_fl, {req, " fail"}, int'(fail), exp_fl);
        if (exp_fl != 0)
            check(int'(fail_idx) == exp_ix, {req, " fail_idx"}, int'(fail_idx), exp_ix);
        else
            check(t == RUN_LEN, "R9 run length", t, RUN_LEN);
        @(negedge clk);
        check(done == 1'b0, "R9 done one cycle", int'(done), 0);
        @(negedge clk);
        check(int'(fail) == exp_fl, "R10 fail held idle", int'(fail), exp_fl);
    endtask

    initial begin
        #(20ns * 190000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(test_en == '0 && !chain_in && !done && !fail && fail_idx == '0,
              "R1 reset outputs", int'(test_en), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // clean run with full stimulus comparison (R3 R5 R6 R7 R9)
        run_case(0, 0, "R9 clean", 1'b1, 1'b0);
        // stray start mid-run (R2)
        run_case(0, 0, "R2 stray start", 1'b0, 1'b1);

        // stuck outputs break the chain (R4)
        for (int u = 0; u < N; u++) begin
            for (int v = 0; v < 2; v++) begin
                s_unit = u; s_val = v[0];
                run_case(1, ALL1, "R4 stuck unit", 1'b0, 1'b0);
            end
        end
        s_unit = -1;
        // fail cleared by next start (R10)
        run_case(0, 0, "R10 cleared by start", 1'b0, 1'b0);

        // single truth-table bit flips everywhere (R7 R8)
        for (int u = 0; u < N; u++) begin
            for (int c = 0; c < 11; c++) begin
                for (int m = 0; m < 4; m++) begin
                    int det;
                    f_unit = u; f_cfg = c; f_mask = 1 << m;
                    det = (b_resp(c, 0) != b_resp(c, 1 << m)) ? 1 : 0;
                    run_case(det, u, det != 0 ? "R8 caught flip" : "R7 masked flip", 1'b0, 1'b0);
                end
            end
        end
        f_unit = -1;

        // reset mid-run (R1)
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (60) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(test_en == '0 && !chain_in && !done, "R1 reset mid-run", int'(test_en), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(test_en == '0 && !done, "R1 stays idle", int'(test_en), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule